// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns read and write column commands into a per-cycle column address stream for a four-bank SDRAM data path with 32-bit data. It also produces the timing strobes that go with the stream. A command supplies the starting column. The block then steps through the burst in sequential or interleaved order over the programmed length, which is 1, 2, 4 or 8 beats or a full 256-column page. It raises a write strobe with per-byte enables for write beats. For read beats it raises a read-valid strobe and per-lane output enables once the CAS latency has passed.

The mode fields arrive already decoded from elsewhere. Burst length, ordering and the single-beat-write setting are captured when a command is accepted. CAS latency is applied as it stands each cycle. A burst stop ends the address stream, and so does a fresh column command, which restarts the stream at once. Read beats that were already issued still come out of the latency pipeline.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs are driven low from the next cycle on: col_addr, col_valid, col_is_wr, wr_en, wr_byte_en, rd_valid and rd_oe.
- R2: A command sampled at edge k shows its first beat during the cycle after edge k, with col_addr equal to cmd_col and col_valid high. The block then shows one beat per cycle. col_is_wr is 1 for a write, and when cmd_rd and cmd_wr are both high the write is taken.
- R3: cfg_burst_len selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. Codes 4, 5 and 6 give 1 beat. col_valid falls in the cycle after the last beat.
- R4: When cfg_interleave is 0, each beat keeps the column bits above the burst boundary from the start column. The low bits are (start + beat index) modulo the burst length.
- R5: When cfg_interleave is 1 and the burst is not a full page, the low bits are (start XOR beat index) within the burst length. The upper bits are unchanged.
- R6: A full-page burst always counts upward, whatever cfg_interleave is set to. It wraps from column 255 to column 0 and continues until it is stopped or interrupted.
- R7: A cmd_stop sampled with no new command drives col_valid low from the next cycle, at any burst length.
- R8: A new command sampled during a burst discards the old burst. The new start column appears in the next cycle.
- R9: With cfg_wr_single at 1, a write lasts one beat. Reads still use the programmed length.
- R10: rd_valid is high exactly cfg_cas_lat cycles after each cycle that shows a read beat. Values 1, 2 and 3 are used as given, and 0 acts as 1.
- R11: Read beats shown before a stop or an interruption still produce rd_valid at their latency.
- R12: In a write beat, wr_en is high and wr_byte_en equals the inverse of dqm in that same cycle. bit n of dqm masks byte lane n.
- R13: rd_oe is rd_valid on every lane, except a lane whose dqm bit was high two cycles earlier, which is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 selects interleaved order |
| cfg_cas_lat | input | 2 | Read latency in clocks |
| cfg_wr_single | input | 1 | 1 limits writes to one beat |
| cmd_rd | input | 1 | Read column command |
| cmd_wr | input | 1 | Write column command |
| cmd_col | input | 8 | Starting column of the command |
| cmd_stop | input | 1 | Burst stop |
| dqm | input | 4 | Per-byte mask |
| col_addr | output | 8 | Column of the current beat, 0 when idle |
| col_valid | output | 1 | A beat is shown this cycle |
| col_is_wr | output | 1 | The current burst is a write |
| wr_en | output | 1 | Write beat strobe |
| wr_byte_en | output | 4 | Per-byte write enable |
| rd_valid | output | 1 | Read data expected this cycle |
| rd_oe | output | 4 | Per-lane read output enable |

## Verification
The hardest case to reach is one where a cut-short burst still has read beats pending in the latency pipeline. The stimulus starts a full-page read with the longest latency, stops it after two beats, and checks that exactly two read-valid cycles follow. A second hard case is placing a read mask so that it lands on one beat two cycles later. The bench raises dqm for a single mid-burst cycle and checks the lane enables before, at and after the cycle it lands on.

// File: rtl/colgen_pkg.sv
// Shared codes and the captured-configuration record for the column sequencer.
// Assumes the burst length code is three bits wide.
package colgen_pkg;
    localparam logic [2:0] BL_CODE_1    = 3'd0;
    localparam logic [2:0] BL_CODE_2    = 3'd1;
    localparam logic [2:0] BL_CODE_4    = 3'd2;
    localparam logic [2:0] BL_CODE_8    = 3'd3;
    localparam logic [2:0] BL_CODE_PAGE = 3'd7;

    typedef struct packed {
        logic [2:0] bl;
        logic       interleave;
        logic       wr_single;
    } burst_cfg_t;
endpackage

// File: rtl/sdram_burst_ctrl.sv
// Burst state holder. It accepts column commands, keeps the start column and
// the beat count, and ends the burst on its last beat, on a stop, or when a
// new command arrives.
// Assumes COL_W >= 3. A new command takes priority over a stop.
module sdram_burst_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_cfg_t       cfg,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    output logic             active,
    output logic             is_wr,
    output logic             seq_il,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] mask
);
    logic             active_q, is_wr_q, page_q, il_q;
    logic [COL_W-1:0] base_q, cnt_q, mask_q;
    logic             start;

    // Low-bit mask for a length code; a full page covers every column bit
    function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        case (code)
            BL_CODE_2:    m = COL_W'(1);
            BL_CODE_4:    m = COL_W'(3);
            BL_CODE_8:    m = COL_W'(7);
            BL_CODE_PAGE: m = '1;
            default:      m = '0;
        endcase
        return m;
    endfunction

    assign start = cmd_rd | cmd_wr;

    // Burst state update: start, stop, advance or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            is_wr_q  <= 1'b0;
            page_q   <= 1'b0;
            il_q     <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            mask_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            is_wr_q  <= cmd_wr;
            base_q   <= cmd_col;
            cnt_q    <= '0;
            il_q     <= cfg.interleave;
            if (cmd_wr && cfg.wr_single) begin
                mask_q <= '0;
                page_q <= 1'b0;
            end else begin
                mask_q <= len_mask(cfg.bl);
                page_q <= (cfg.bl == BL_CODE_PAGE);
            end
        end else if (cmd_stop) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (!page_q && (cnt_q == mask_q)) begin
                active_q <= 1'b0;
            end
            cnt_q <= cnt_q + COL_W'(1);
        end
    end

    assign active = active_q;
    assign is_wr  = is_wr_q;
    assign seq_il = il_q & ~page_q;
    assign base   = base_q;
    assign cnt    = cnt_q;
    assign mask   = mask_q;
endmodule

// File: rtl/sdram_col_order.sv
// Column order logic. It combines the start column and the beat index into
// the beat's column. The low bits (under mask) count up or are XORed; the
// upper bits keep the start value.
// Assumes mask is a contiguous run of ones from bit 0. IL_EN = 0 builds
// only the counting order.
module sdram_col_order #(
    parameter int COL_W = 8,
    parameter bit IL_EN = 1'b1
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low;

    generate
        if (IL_EN) begin : g_both
            // Pick the counting or the XOR order
            assign low = interleave ? (base ^ cnt) : (base + cnt);
        end else begin : g_seq_only
            // Counting order only
            assign low = base + cnt;
        end
    endgenerate

    assign col = (base & ~mask) | (low & mask);
endmodule

// File: rtl/sdram_rd_timing.sv
// Read timing. It delays each read beat by the programmed latency to form
// rd_valid, and delays the byte mask by DQM_LAT cycles to gate the lane
// enables.
// Assumes MAX_CL >= 2 and DQM_LAT >= 1. A latency of 0 acts as 1, and a
// latency above MAX_CL is clipped to MAX_CL.
module sdram_rd_timing #(
    parameter int LANES   = 4,
    parameter int MAX_CL  = 3,
    parameter int DQM_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_beat,
    input  logic [1:0]       cas_lat,
    input  logic [LANES-1:0] dqm,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_oe
);
    localparam int SEL_W = $clog2(MAX_CL);

    logic [MAX_CL-1:0] pipe_q;
    logic [SEL_W-1:0]  tap;
    logic [LANES-1:0]  dqm_q [DQM_LAT];

    // Shift the read-beat marks along the latency line
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[MAX_CL-2:0], rd_beat};
    end

    generate
        for (genvar s = 0; s < DQM_LAT; s++) begin : g_dqm
            if (s == 0) begin : g_first
                // First stage of the mask delay
                always_ff @(posedge clk) begin
                    if (!rst_n) dqm_q[s] <= '0;
                    else        dqm_q[s] <= dqm;
                end
            end else begin : g_next
                // Later stages of the mask delay
                always_ff @(posedge clk) begin
                    if (!rst_n) dqm_q[s] <= '0;
                    else        dqm_q[s] <= dqm_q[s-1];
                end
            end
        end
    endgenerate

    // Pick the pipeline tap for the current latency
    always_comb begin
        if (cas_lat == 2'd0)             tap = '0;
        else if (int'(cas_lat) > MAX_CL) tap = SEL_W'(MAX_CL - 1);
        else                             tap = SEL_W'(int'(cas_lat) - 1);
    end

    assign rd_valid = pipe_q[tap];
    assign rd_oe    = rd_valid ? ~dqm_q[DQM_LAT-1] : '0;
endmodule

// File: rtl/sdram_burst_colgen.sv
// Top of the column sequencer. It joins the burst state, the column order
// and the read timing, and applies the write byte mask with no delay.
// Assumes decoded mode fields are held steady around each command.
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int LANES  = 4,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_burst_len,
    input  logic             cfg_interleave,
    input  logic [1:0]       cfg_cas_lat,
    input  logic             cfg_wr_single,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [LANES-1:0] dqm,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_is_wr,
    output logic             wr_en,
    output logic [LANES-1:0] wr_byte_en,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_oe
);
    burst_cfg_t       cfg;
    logic             active, is_wr, seq_il;
    logic [COL_W-1:0] base, cnt, mask, col;

    assign cfg = '{bl: cfg_burst_len, interleave: cfg_interleave,
                   wr_single: cfg_wr_single};

    sdram_burst_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
        .active(active), .is_wr(is_wr), .seq_il(seq_il),
        .base(base), .cnt(cnt), .mask(mask)
    );

    sdram_col_order #(.COL_W(COL_W), .IL_EN(1'b1)) order_i (
        .base(base), .cnt(cnt), .mask(mask), .interleave(seq_il), .col(col)
    );

    sdram_rd_timing #(.LANES(LANES), .MAX_CL(MAX_CL), .DQM_LAT(2)) rdt_i (
        .clk(clk), .rst_n(rst_n), .rd_beat(active & ~is_wr),
        .cas_lat(cfg_cas_lat), .dqm(dqm), .rd_valid(rd_valid), .rd_oe(rd_oe)
    );

    assign col_addr   = active ? col : '0;
    assign col_valid  = active;
    assign col_is_wr  = active & is_wr;
    assign wr_en      = active & is_wr;
    assign wr_byte_en = (active & is_wr) ? ~dqm : '0;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
// Property checker for the column sequencer, attached to the top by bind.
module sdram_burst_colgen_chk #(
    parameter int COL_W = 8,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_single,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_is_wr,
    input logic             wr_en,
    input logic [LANES-1:0] wr_byte_en,
    input logic             rd_valid,
    input logic [LANES-1:0] rd_oe
);
    AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n) (cmd_rd || cmd_wr) |=> (col_valid && col_addr == $past(cmd_col))); // R2
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_stop && !cmd_rd && !cmd_wr) |=> !col_valid); // R7
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(cmd_wr && cfg_wr_single, 2) && !$past(cmd_rd || cmd_wr)) |-> !col_valid); // R9
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> ($past(col_valid && !col_is_wr, 1) || $past(col_valid && !col_is_wr, 2) || $past(col_valid && !col_is_wr, 3))); // R10
    AST_BYTE_EN_WR: assert property (@(posedge clk) disable iff (!rst_n) (|wr_byte_en) |-> (wr_en && col_is_wr)); // R12
    AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (|rd_oe) |-> rd_valid); // R13
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W), .LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_single(cfg_wr_single),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
    .col_addr(col_addr), .col_valid(col_valid), .col_is_wr(col_is_wr),
    .wr_en(wr_en), .wr_byte_en(wr_byte_en), .rd_valid(rd_valid), .rd_oe(rd_oe)
);

// File: tb/sdram_burst_colgen_tb_top.sv
// Self-checking bench for the column sequencer: an ordering table, then
// directed cases.
module sdram_burst_colgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_burst_len = '0;
    logic       cfg_interleave = 1'b0;
    logic [1:0] cfg_cas_lat = 2'd1;
    logic       cfg_wr_single = 1'b0;
    logic       cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0;
    logic [7:0] cmd_col = '0;
    logic [3:0] dqm = '0;
    logic [7:0] col_addr;
    logic       col_valid, col_is_wr, wr_en, rd_valid;
    logic [3:0] wr_byte_en, rd_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_burst_len),
        .cfg_interleave(cfg_interleave), .cfg_cas_lat(cfg_cas_lat),
        .cfg_wr_single(cfg_wr_single), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_col(cmd_col), .cmd_stop(cmd_stop), .dqm(dqm),
        .col_addr(col_addr), .col_valid(col_valid), .col_is_wr(col_is_wr),
        .wr_en(wr_en), .wr_byte_en(wr_byte_en), .rd_valid(rd_valid), .rd_oe(rd_oe)
    );

    // {len code, interleave, start col, beats, columns with beat 0 in [7:0]}
    localparam logic [79:0] VEC [0:6] = '{
        {3'd2, 1'b0, 8'h0D, 4'd4, 64'h00000000_0C0F0E0D},
        {3'd2, 1'b1, 8'h0D, 4'd4, 64'h00000000_0E0F0C0D},
        {3'd3, 1'b0, 8'h15, 4'd8, 64'h14131211_10171615},
        {3'd3, 1'b1, 8'h15, 4'd8, 64'h12131011_16171415},
        {3'd1, 1'b1, 8'h33, 4'd2, 64'h00000000_00003233},
        {3'd0, 1'b0, 8'h7F, 4'd1, 64'h00000000_0000007F},
        {3'd5, 1'b0, 8'h44, 4'd1, 64'h00000000_00000044}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a command at a negedge; return at the negedge after it is sampled
    task automatic start_cmd(input logic rd, input logic wr, input logic [7:0] col);
        cmd_rd = rd; cmd_wr = wr; cmd_col = col;
        @(posedge clk);
        @(negedge clk);
        cmd_rd = 1'b0; cmd_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3);
        check({col_addr, col_valid, col_is_wr, wr_en, wr_byte_en, rd_valid, rd_oe} == '0,
              "R1 reset outputs", col_valid, 0);
        rst_n = 1'b1;
        idle(2);

        // Ordering table: R3, R4, R5
        for (int v = 0; v < 7; v++) begin
            logic [79:0] e;
            e = VEC[v];
            cfg_burst_len = e[79:77];
            cfg_interleave = e[76];
            start_cmd(1'b1, 1'b0, e[75:68]);
            for (int b = 0; b < int'(e[67:64]); b++) begin
                if (b > 0) step();
                check(col_valid && col_addr == e[b*8 +: 8], e[76] ? "R5 interleaved col" : "R4 sequential col",
                      col_addr, e[b*8 +: 8]);
            end
            step();
            check(!col_valid, "R3 burst end", col_valid, 0);
            idle(4);
        end

        // R6: full page ignores interleave, wraps, runs until stopped
        cfg_burst_len = 3'd7; cfg_interleave = 1'b1;
        start_cmd(1'b1, 1'b0, 8'hFE);
        check(col_addr == 8'hFE, "R6 page beat0", col_addr, 8'hFE);
        step();
        check(col_addr == 8'hFF, "R6 page beat1", col_addr, 8'hFF);
        step();
        check(col_addr == 8'h00, "R6 page wrap", col_addr, 8'h00);
        idle(7);
        check(col_valid && col_addr == 8'h07, "R6 page beat9", col_addr, 8'h07);
        cmd_stop = 1'b1;
        step();
        cmd_stop = 1'b0;
        check(!col_valid, "R7 stop full page", col_valid, 0);
        idle(4);

        // R7, R11: stop with reads in flight, latency 3
        cfg_interleave = 1'b0; cfg_cas_lat = 2'd3;
        start_cmd(1'b1, 1'b0, 8'h10);
        step();
        cmd_stop = 1'b1;
        step();
        cmd_stop = 1'b0;
        check(!col_valid, "R7 stop", col_valid, 0);
        step();
        check(rd_valid, "R11 in-flight beat0", rd_valid, 1);
        step();
        check(rd_valid, "R11 in-flight beat1", rd_valid, 1);
        step();
        check(!rd_valid, "R11 nothing after stop", rd_valid, 0);
        idle(4);

        // R10: read latency 1, 2, 3 and 0 acting as 1
        for (int cl = 0; cl < 4; cl++) begin
            int eff;
            eff = (cl == 0) ? 1 : cl;
            cfg_cas_lat = 2'(cl); cfg_burst_len = 3'd0;
            start_cmd(1'b1, 1'b0, 8'h00);
            for (int j = 0; j <= eff + 1; j++) begin
                if (j > 0) step();
                check(rd_valid == (j == eff), "R10 read latency", rd_valid, (j == eff));
            end
            idle(4);
        end

        // R13: read mask lands two cycles later, latency 2, burst of 4
        cfg_cas_lat = 2'd2; cfg_burst_len = 3'd2;
        start_cmd(1'b1, 1'b0, 8'h00);
        step();
        dqm = 4'b0001;
        step();
        dqm = 4'b0000;
        check(rd_oe == 4'b1111, "R13 oe before mask", rd_oe, 4'b1111);
        step();
        check(rd_oe == 4'b1110, "R13 oe masked lane0", rd_oe, 4'b1110);
        step();
        check(rd_oe == 4'b1111, "R13 oe after mask", rd_oe, 4'b1111);
        idle(2);
        check(rd_oe == 4'b0000, "R13 oe idle", rd_oe, 0);
        idle(3);

        // R12: write mask acts in the same cycle; writes raise no rd_valid
        cfg_cas_lat = 2'd1; cfg_burst_len = 3'd1; cfg_wr_single = 1'b0;
        start_cmd(1'b0, 1'b1, 8'h20);
        dqm = 4'b0101;
        #1;
        check(wr_en && col_is_wr && wr_byte_en == 4'b1010, "R12 write mask", wr_byte_en, 4'b1010);
        step();
        dqm = 4'b0000;
        #1;
        check(wr_en && col_addr == 8'h21 && wr_byte_en == 4'b1111, "R12 write beat1", wr_byte_en, 4'b1111);
        check(!rd_valid, "R2 write gives no rd_valid", rd_valid, 0);
        step();
        check(!wr_en && !rd_valid, "R3 write end", wr_en, 0);
        idle(3);

        // R9: single-beat writes, reads still full length
        cfg_wr_single = 1'b1; cfg_burst_len = 3'd2;
        start_cmd(1'b0, 1'b1, 8'h30);
        check(wr_en && col_addr == 8'h30, "R9 single write beat", col_addr, 8'h30);
        step();
        check(!col_valid, "R9 single write ends", col_valid, 0);
        idle(2);
        start_cmd(1'b1, 1'b0, 8'h30);
        idle(3);
        check(col_valid && col_addr == 8'h33, "R9 read keeps length", col_addr, 8'h33);
        idle(4);
        cfg_wr_single = 1'b0;

        // R8: a new command interrupts a burst
        cfg_burst_len = 3'd3;
        start_cmd(1'b1, 1'b0, 8'h00);
        step();
        start_cmd(1'b1, 1'b0, 8'h40);
        check(col_valid && col_addr == 8'h40, "R8 interrupt start", col_addr, 8'h40);
        step();
        check(col_addr == 8'h41, "R8 interrupt continues", col_addr, 8'h41);
        idle(10);

        // R2: write wins when both strobes are high
        start_cmd(1'b1, 1'b1, 8'h55);
        check(col_is_wr && col_addr == 8'h55, "R2 write priority", col_is_wr, 1);
        idle(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule